// File: doc/BRIEF.md
# APB Peripheral Register File

This block is the software-visible control surface of a small peripheral. It sits on an APB slave port and holds four 32-bit word-aligned registers: a control word, a status word, a general data word and an interrupt status word. The control word drives the core's enable, mode and interrupt-enable inputs. The status word shows the core's busy, error and done levels as they are at that moment. The interrupt status word collects event pulses from the core until software clears them.

Every transfer finishes with no wait states. Writes respect the byte strobes. The single interrupt line is raised while interrupts are enabled and at least one latched event is pending. Read data, ready and error responses are registered in the setup phase, so all bus outputs come straight from flops.

Top module: `periph_regfile`

## Requirements
- R1: After reset the control, data and interrupt status registers read 0. The outputs ctl_enable, ctl_mode, ctl_irq_en and irq_out are 0.
- R2: The control register is at offset 0x00. Its fields are enable at bit 0, mode at bits 2:1 and interrupt enable at bit 3. All are read-write and appear on the matching outputs. Bits 31:4 read 0 whatever was written.
- R3: The status register is at offset 0x04. It reads busy at bit 0, error at bit 1 and done at bit 2, taken from the live inputs. Bits 31:3 read 0. A write to it changes nothing and completes without error.
- R4: The data register is at offset 0x08. It is a 32-bit read-write register, and a written value reads back unchanged.
- R5: In every writable register, a byte lane whose pstrb bit is low keeps its old contents. Control and interrupt status use lane 0 (pstrb[0]).
- R6: The interrupt status register is at offset 0x0C, bits 3:0. Writing 1 to a bit clears it and writing 0 leaves it as it is. Bits 31:4 read 0.
- R7: A pulse on irq_event[i] sets interrupt status bit i. When a set and a clear hit the same bit in the same cycle, the bit stays set.
- R8: irq_out is 1 exactly when the interrupt enable bit is 1 and any interrupt status bit is 1.
- R9: Every transfer is one setup cycle followed by one access cycle. pready is 1 in the access cycle.
- R10: An access to an unmapped offset sets pslverr to 1 in the access cycle. Unmapped means offset 0x10 or above, or address bits 1:0 not zero. A read of such an offset returns 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| pstrb | input | DATA_W/8 | APB byte write strobes |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready |
| pslverr | output | 1 | APB error response |
| ctl_enable | output | 1 | Core enable |
| ctl_mode | output | 2 | Core mode select |
| ctl_irq_en | output | 1 | Interrupt enable |
| stat_busy | input | 1 | Core busy level |
| stat_error | input | 1 | Core error level |
| stat_done | input | 1 | Core done level |
| irq_event | input | IRQ_N | Per-source interrupt event pulses |
| irq_out | output | 1 | Interrupt request |

## Verification
Two functions can act on the interrupt status register in the same cycle: the hardware set from irq_event and the write-1-to-clear from software. The bench provokes this by raising the event pulse during the access cycle of a clearing write to the same bit. It also does this with a clear mask that covers another bit as well. The result is then read back. A bit that was both set and cleared must stay 1, and a bit that was only cleared must read 0. irq_out is checked against the enable bit around these events.

// File: rtl/periph_regfile_pkg.sv
package periph_regfile_pkg;
  localparam int REG_N = 4;

  typedef enum logic [1:0] {
    RIDX_CTRL = 2'd0,
    RIDX_STAT = 2'd1,
    RIDX_DATA = 2'd2,
    RIDX_IRQ  = 2'd3
  } reg_idx_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_MODE_LSB  = 1;
  localparam int CTRL_MODE_W    = 2;
  localparam int CTRL_IRQEN_BIT = 3;
  localparam int CTRL_W         = 4;
  localparam int STAT_W         = 3;
endpackage

// File: rtl/periph_apb_decode.sv
module periph_apb_decode #(
  parameter int ADDR_W = 12,
  parameter int REG_N  = 4
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              setup_ph,
  output logic              wr_acc,
  output logic              mapped,
  output logic [REG_N-1:0]  sel
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] word_idx;

  assign word_idx = paddr[ADDR_W-1:2];
  assign setup_ph = psel & ~penable;
  assign wr_acc   = psel & penable & pwrite;
  assign mapped   = (paddr[1:0] == 2'b00) && (word_idx < IW'(REG_N));

  for (genvar g = 0; g < REG_N; g++) begin : g_sel
    assign sel[g] = mapped && (word_idx == IW'(g));
  end
endmodule

// File: rtl/periph_byte_reg.sv
module periph_byte_reg #(
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [STRB_W-1:0] strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        q[8*g +: 8] <= 8'h00;
      else if (we && strb[g])
        q[8*g +: 8] <= wdata[8*g +: 8];
    end

    // R5: a lane without its strobe keeps its bytes
    a_r5_lane_hold: assert property (@(posedge clk) disable iff (rst)
      !(we && strb[g]) |=> $stable(q[8*g +: 8]));
  end
endmodule

// File: rtl/periph_irq_status.sv
module periph_irq_status #(
  parameter int IRQ_N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_N-1:0] clr_mask,
  input  logic [IRQ_N-1:0] set_mask,
  output logic [IRQ_N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_mask) | set_mask;
  end

  // R7: an event always leaves its bit set, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((q & $past(set_mask)) == $past(set_mask)));

  // R6: a bit only falls when software wrote 1 to it
  a_r6_clear_only_w1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((($past(q) & ~q) & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/periph_regfile.sv
module periph_regfile
  import periph_regfile_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IRQ_N  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  input  logic [DATA_W/8-1:0]   pstrb,
  output logic [DATA_W-1:0]     prdata,
  output logic                  pready,
  output logic                  pslverr,
  output logic                  ctl_enable,
  output logic [1:0]            ctl_mode,
  output logic                  ctl_irq_en,
  input  logic                  stat_busy,
  input  logic                  stat_error,
  input  logic                  stat_done,
  input  logic [IRQ_N-1:0]      irq_event,
  output logic                  irq_out
);
  localparam int STRB_W = DATA_W / 8;

  logic              setup_ph, wr_acc, mapped;
  logic [REG_N-1:0]  sel;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] data_q;
  logic [IRQ_N-1:0]  irq_q, irq_clr;
  logic [DATA_W-1:0] rd_word;

  periph_apb_decode #(.ADDR_W(ADDR_W), .REG_N(REG_N)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .setup_ph(setup_ph), .wr_acc(wr_acc), .mapped(mapped), .sel(sel)
  );

  // control word, lane 0 only
  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr_acc && sel[int'(RIDX_CTRL)] && pstrb[0])
      ctrl_q <= pwdata[CTRL_W-1:0];
  end

  assign ctl_enable = ctrl_q[CTRL_EN_BIT];
  assign ctl_mode   = ctrl_q[CTRL_MODE_LSB +: CTRL_MODE_W];
  assign ctl_irq_en = ctrl_q[CTRL_IRQEN_BIT];

  periph_byte_reg #(.DATA_W(DATA_W), .STRB_W(STRB_W)) u_data (
    .clk(clk), .rst(rst),
    .we(wr_acc && sel[int'(RIDX_DATA)]),
    .strb(pstrb), .wdata(pwdata), .q(data_q)
  );

  assign irq_clr = (wr_acc && sel[int'(RIDX_IRQ)] && pstrb[0]) ?
                   pwdata[IRQ_N-1:0] : '0;

  periph_irq_status #(.IRQ_N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst), .clr_mask(irq_clr), .set_mask(irq_event), .q(irq_q)
  );

  assign irq_out = ctrl_q[CTRL_IRQEN_BIT] & (|irq_q);

  always_comb begin
    rd_word = '0;
    if (sel[int'(RIDX_CTRL)]) rd_word[CTRL_W-1:0] = ctrl_q;
    if (sel[int'(RIDX_STAT)]) rd_word[STAT_W-1:0] = {stat_done, stat_error, stat_busy};
    if (sel[int'(RIDX_DATA)]) rd_word = data_q;
    if (sel[int'(RIDX_IRQ)])  rd_word[IRQ_N-1:0] = irq_q;
  end

  // response registered during setup, presented in access
  always_ff @(posedge clk) begin
    if (rst) begin
      prdata  <= '0;
      pready  <= 1'b0;
      pslverr <= 1'b0;
    end else begin
      pready  <= setup_ph;
      pslverr <= setup_ph & ~mapped;
      prdata  <= (setup_ph && !pwrite) ? rd_word : '0;
    end
  end

  // R9: no wait states
  a_r9_ready_in_access: assert property (@(posedge clk) disable iff (rst)
    (psel && penable) |-> pready);

  // R10: error response carries no data
  a_r10_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    pslverr |-> (prdata == '0));

  // R8: interrupt line needs the enable
  a_r8_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ctl_irq_en);

  // R3: status read shows the inputs seen at setup
  a_r3_status_live: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pwrite && sel[int'(RIDX_STAT)]) |->
      (prdata == DATA_W'($past({stat_done, stat_error, stat_busy}))));

  // R2: reserved control bits read zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pwrite && sel[int'(RIDX_CTRL)]) |->
      (prdata[DATA_W-1:CTRL_W] == '0));
endmodule

// File: tb/periph_regfile_bench.sv
module periph_regfile_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        ctl_enable, ctl_irq_en, irq_out;
  logic [1:0]  ctl_mode;
  logic        stat_busy = 0, stat_error = 0, stat_done = 0;
  logic [3:0]  irq_event = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  periph_regfile u_periph_regfile (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .ctl_enable(ctl_enable),
    .ctl_mode(ctl_mode), .ctl_irq_en(ctl_irq_en), .stat_busy(stat_busy),
    .stat_error(stat_error), .stat_done(stat_done), .irq_event(irq_event),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [11:0] a, input logic wr, input logic [31:0] d,
                      input logic [3:0] s, input logic [3:0] ev,
                      output logic [31:0] rd, output logic err, output logic rdy);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1; irq_event = ev;
    #1; rd = prdata; err = pslverr; rdy = pready;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; pstrb = '0; irq_event = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                    output logic err);
    logic [31:0] rd; logic rdy;
    xfer(a, 1'b1, d, s, 4'h0, rd, err, rdy);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic err, rdy;
    xfer(a, 1'b0, '0, '0, 4'h0, rd, err, rdy);
    chk(req, rd, exp);
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk); irq_event = ev;
    @(negedge clk); irq_event = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 12'h000, 32'h0);
    rd_chk("R1 data", 12'h008, 32'h0);
    rd_chk("R1 irq", 12'h00C, 32'h0);
    chk("R1 outputs", {28'b0, ctl_enable, ctl_mode, ctl_irq_en}, 32'h0);
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_ctrl;
    logic e;
    wr(12'h000, 32'hFFFF_FFFF, 4'hF, e);
    rd_chk("R2 reserved", 12'h000, 32'h0000_000F);
    chk("R2 fields all", {28'b0, ctl_irq_en, ctl_mode, ctl_enable}, 32'hF);
    wr(12'h000, 32'h0000_0005, 4'hF, e);
    rd_chk("R2 readback", 12'h000, 32'h5);
    chk("R2 mode", {30'b0, ctl_mode}, 32'h2);
    chk("R2 enable", {31'b0, ctl_enable}, 32'h1);
    wr(12'h000, 32'h0000_000A, 4'hE, e);
    rd_chk("R5 ctrl lane0 off", 12'h000, 32'h5);
  endtask

  task automatic t_status;
    logic e;
    stat_busy = 1; stat_error = 0; stat_done = 1;
    rd_chk("R3 live 101", 12'h004, 32'h5);
    wr(12'h004, 32'hFFFF_FFFF, 4'hF, e);
    chk("R3 write no err", {31'b0, e}, 32'h0);
    rd_chk("R3 after write", 12'h004, 32'h5);
    stat_busy = 0; stat_error = 1; stat_done = 0;
    rd_chk("R3 live 010", 12'h004, 32'h2);
  endtask

  task automatic t_data;
    logic e;
    wr(12'h008, 32'hDEAD_BEEF, 4'hF, e);
    rd_chk("R4 readback", 12'h008, 32'hDEAD_BEEF);
    wr(12'h008, 32'h1122_3344, 4'b0101, e);
    rd_chk("R5 data strobes", 12'h008, 32'hDE22_BE44);
  endtask

  task automatic t_irq;
    logic e; logic [31:0] rd; logic rdy;
    wr(12'h000, 32'h0, 4'hF, e);
    pulse(4'hA);
    rd_chk("R7 event sets", 12'h00C, 32'hA);
    chk("R8 masked", {31'b0, irq_out}, 32'h0);
    wr(12'h000, 32'h8, 4'hF, e);
    chk("R8 enabled", {31'b0, irq_out}, 32'h1);
    wr(12'h00C, 32'hFFFF_FFF2, 4'hF, e);
    rd_chk("R6 w1c", 12'h00C, 32'h8);
    wr(12'h00C, 32'h0, 4'hF, e);
    rd_chk("R6 write0 keeps", 12'h00C, 32'h8);
    wr(12'h00C, 32'hF, 4'h0, e);
    rd_chk("R5 irq lane0 off", 12'h00C, 32'h8);
    xfer(12'h00C, 1'b1, 32'h8, 4'hF, 4'h8, rd, e, rdy);
    rd_chk("R7 set beats clear", 12'h00C, 32'h8);
    xfer(12'h00C, 1'b1, 32'h9, 4'hF, 4'h1, rd, e, rdy);
    rd_chk("R7 mixed", 12'h00C, 32'h1);
    chk("R8 still pending", {31'b0, irq_out}, 32'h1);
    wr(12'h00C, 32'h1, 4'hF, e);
    chk("R8 none pending", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_bus;
    logic [31:0] rd; logic e, rdy;
    xfer(12'h008, 1'b0, '0, '0, 4'h0, rd, e, rdy);
    chk("R9 ready read", {31'b0, rdy}, 32'h1);
    chk("R9 no err mapped", {31'b0, e}, 32'h0);
    xfer(12'h010, 1'b0, '0, '0, 4'h0, rd, e, rdy);
    chk("R10 read data", rd, 32'h0);
    chk("R10 read err", {31'b0, e}, 32'h1);
    chk("R9 ready unmapped", {31'b0, rdy}, 32'h1);
    xfer(12'h009, 1'b0, '0, '0, 4'h0, rd, e, rdy);
    chk("R10 unaligned err", {31'b0, e}, 32'h1);
    xfer(12'h014, 1'b1, 32'hFFFF_FFFF, 4'hF, 4'h0, rd, e, rdy);
    chk("R10 write err", {31'b0, e}, 32'h1);
    xfer(12'h00A, 1'b1, 32'hFFFF_FFFF, 4'hF, 4'h0, rd, e, rdy);
    rd_chk("R10 ctrl kept", 12'h000, 32'h8);
    rd_chk("R10 data kept", 12'h008, 32'hDE22_BE44);
    rd_chk("R10 irq kept", 12'h00C, 32'h0);
  endtask

  initial begin
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset;
    t_ctrl;
    t_status;
    t_data;
    t_irq;
    t_bus;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule